// File: doc/BRIEF.md
# Shadow-Stack Far-Return Frame Verifier

This sequential unit runs the shadow-stack part of a far return. It starts on a one-cycle `start` pulse. First it checks the alignment of the current shadow-stack pointer. It then fetches a three-entry frame over a 64-bit read port, one request at a time. The frame holds the saved code selector, the saved linear return address and the previous shadow-stack pointer. The unit compares the frame with the return that is being made and validates the pointer it is about to restore. When every check has passed, it frees the busy token at the old pointer through a locked compare-exchange port. The result comes back on a one-cycle `done` pulse with the new pointer, a fault kind and a token-release status.

On a return to user level (privilege 3) no frame is read. The new pointer then comes from the saved user-level pointer input. If `old_en` is low, the unit does nothing beyond finishing with the pointer unchanged.

The control is one state machine, `T_IDLE → T_FETCH → T_CHECK → T_WIDTH → T_TOK_REQ → T_TOK_WAIT → T_FIN → T_IDLE`. Its transitions are as follows:
- `T_IDLE` goes to `T_FIN` when `old_en` is low or the pointer is misaligned.
- `T_IDLE` goes to `T_WIDTH` on a user-level return, and to `T_FETCH` otherwise.
- `T_FETCH` waits for the frame reader's last response.
- `T_CHECK` goes to `T_FIN` on a frame mismatch.
- `T_WIDTH` goes to `T_FIN` on a bad pointer.
- `T_TOK_REQ` waits for `cx_ready`.
- `T_TOK_WAIT` waits for `cx_rvalid`.
- `T_FIN` raises `done` and returns to `T_IDLE`.

The frame reader has its own small machine: `RD_IDLE → RD_REQ → RD_WAIT`. It goes back to `RD_REQ` for each further entry and to `RD_IDLE` after the third.

Top module: `sstk_farret_verifier`

## Requirements
- R1: After reset, `done`, `rd_valid` and `cx_valid` are 0, and `fault` is 0 (none).
- R2: With `old_en` low, the unit issues no read and no compare-exchange. It finishes with `fault` 0 and `new_ssp` equal to `cur_ssp`.
- R3: If `cur_ssp[2:0]` is non-zero, the unit finishes with `fault` = 1 (control-protection, far return) and issues no read.
- R4: The three reads go to `cur_ssp+16`, `cur_ssp+8` and `cur_ssp+0`, in that order, with one outstanding at a time. `rd_valid` and `rd_addr` hold steady until `rd_ready`.
- R5: The entry read at +16 must equal `new_sel` zero-extended to 64 bits. Any difference, including set bits above bit 15, gives `fault` = 1.
- R6: The entry read at +8 must equal `ret_lip`, or else `fault` = 1.
- R7: The entry read at +0 (the previous pointer) must have bits 1:0 clear, or else `fault` = 1.
- R8: A frame mismatch takes priority over the pointer width check, so a frame that fails both reports `fault` = 1.
- R9: With `long_l` at 0, a restored pointer with any of bits 63:32 set gives `fault` = 2 (general-protection).
- R10: With `long_l` at 1, the restored pointer must be sign-extended from bit `VA_W-1` (47 by default), or else `fault` = 2.
- R11: When `dest_pl` is 3, no read is made. The restored pointer is `user_ssp`, and the token address is `cur_ssp`.
- R12: After all checks pass, one compare-exchange is issued. Its address is the token address (`cur_ssp+24` after a frame read). `cx_expect` is that address with bit 0 set, and `cx_new` is that address with bit 0 cleared. No compare-exchange is issued on a fault.
- R13: A failed compare-exchange (`cx_ok` = 0) sets `tok_fail` but raises no fault, and the restored pointer is still returned.
- R14: `done` is a one-cycle pulse. At `done`, `new_ssp` is the restored pointer on success and `cur_ssp` on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts a return |
| cur_ssp | input | 64 | Current shadow-stack pointer |
| new_sel | input | 16 | Code selector being returned to |
| ret_lip | input | 64 | Code base plus return pointer |
| dest_pl | input | 2 | Destination privilege level |
| user_ssp | input | 64 | Saved user-level shadow-stack pointer |
| long_l | input | 1 | Long-mode code flag of the target |
| old_en | input | 1 | Shadow stack enabled at the old level |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 64 | Read address |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 64 | Read data |
| cx_valid | output | 1 | Compare-exchange request valid |
| cx_addr | output | 64 | Token address |
| cx_expect | output | 64 | Expected token value (busy) |
| cx_new | output | 64 | Value written when it matches (free) |
| cx_ready | input | 1 | Compare-exchange accepted |
| cx_rvalid | input | 1 | Compare-exchange result valid |
| cx_ok | input | 1 | Compare matched and the write was done |
| new_ssp | output | 64 | Resulting shadow-stack pointer |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 control-protection, 2 general-protection |
| tok_fail | output | 1 | Token release did not match |

## Verification
Two failures can fall in the same pass of the checks: a frame mismatch and a bad restored pointer. The bench builds a frame whose previous-pointer entry is misaligned and also carries high bits that `long_l` = 0 forbids. It requires control-protection rather than general-protection, with no token request. A second overlap is a successful return whose token compare-exchange fails. There the bench requires no fault, a set `tok_fail` and the restored pointer all at the same `done`.

// File: rtl/sstk_pkg.sv
package sstk_pkg;
    localparam int SSTK_DW    = 64;
    localparam int SSTK_N_ENT = 3;
    localparam int IDX_SEL    = 0;
    localparam int IDX_LIP    = 1;
    localparam int IDX_PREV   = 2;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_CP   = 2'd1,
        FLT_GP   = 2'd2
    } flt_e;

    typedef enum logic [2:0] {
        T_IDLE,
        T_FETCH,
        T_CHECK,
        T_WIDTH,
        T_TOK_REQ,
        T_TOK_WAIT,
        T_FIN
    } top_st_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_REQ,
        RD_WAIT
    } rd_st_e;
endpackage

// File: rtl/sstk_frame_reader.sv
module sstk_frame_reader
    import sstk_pkg::*;
#(
    parameter int DW      = SSTK_DW,
    parameter int N_ENT   = SSTK_N_ENT,
    parameter int ENTRY_B = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [DW-1:0]              base,
    output logic                       rd_valid,
    output logic [DW-1:0]              rd_addr,
    input  logic                       rd_ready,
    input  logic                       rd_rvalid,
    input  logic [DW-1:0]              rd_rdata,
    output logic [N_ENT-1:0][DW-1:0]   ent_q,
    output logic                       fin
);
    localparam int IW = $clog2(N_ENT + 1);

    rd_st_e          st, st_nx;
    logic [IW-1:0]   idx;
    logic [DW-1:0]   base_q;
    logic [DW-1:0]   off;
    logic            last;

    assign last = (idx == IW'(N_ENT - 1));
    // highest entry first: the offset falls by one entry per step
    assign off  = DW'((N_ENT - 1 - int'(idx)) * ENTRY_B);

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_IDLE: if (go)        st_nx = RD_REQ;
            RD_REQ:  if (rd_ready)  st_nx = RD_WAIT;
            RD_WAIT: if (rd_rvalid) st_nx = last ? RD_IDLE : RD_REQ;
            default:                st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            base_q <= '0;
            ent_q  <= '0;
        end else begin
            if (st == RD_IDLE && go) begin
                idx    <= '0;
                base_q <= base;
            end
            if (st == RD_WAIT && rd_rvalid) begin
                ent_q[idx] <= rd_rdata;
                idx        <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        rd_valid = (st == RD_REQ);
        rd_addr  = base_q + off;
        fin      = (st == RD_WAIT) && rd_rvalid && last;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R4
endmodule

// File: rtl/sstk_frame_chk.sv
module sstk_frame_chk
    import sstk_pkg::*;
#(
    parameter int DW    = SSTK_DW,
    parameter int SEL_W = 16,
    parameter int N_ENT = SSTK_N_ENT
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic [DW-1:0]             lip,
    input  logic [N_ENT-1:0][DW-1:0]  ent,
    output flt_e                      flt
);
    logic [DW-1:0] sel_ext;
    logic          bad_sel, bad_lip, bad_prev;

    assign sel_ext  = {{(DW-SEL_W){1'b0}}, sel};
    assign bad_sel  = (sel_ext != ent[IDX_SEL]);
    assign bad_lip  = (lip != ent[IDX_LIP]);
    assign bad_prev = (ent[IDX_PREV][1:0] != 2'b00);

    always_comb begin
        if (bad_sel || bad_lip || bad_prev) flt = FLT_CP;
        else                                flt = FLT_NONE;
    end
endmodule

// File: rtl/sstk_width_chk.sv
module sstk_width_chk #(
    parameter int DW   = 64,
    parameter int VA_W = 48
) (
    input  logic [DW-1:0] ssp,
    input  logic          long_l,
    output logic          bad
);
    localparam int HI = DW - (VA_W - 1);

    logic [HI-1:0] ext;
    logic          noncanon;
    logic          hi32;

    assign ext      = ssp[DW-1:VA_W-1];
    assign noncanon = !((&ext) || !(|ext));
    assign hi32     = |ssp[DW-1:32];
    assign bad      = long_l ? noncanon : hi32;
endmodule

// File: rtl/sstk_farret_verifier.sv
module sstk_farret_verifier
    import sstk_pkg::*;
#(
    parameter int SEL_W   = 16,
    parameter int VA_W    = 48,
    parameter int ENTRY_B = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [63:0]  cur_ssp,
    input  logic [15:0]  new_sel,
    input  logic [63:0]  ret_lip,
    input  logic [1:0]   dest_pl,
    input  logic [63:0]  user_ssp,
    input  logic         long_l,
    input  logic         old_en,
    output logic         rd_valid,
    output logic [63:0]  rd_addr,
    input  logic         rd_ready,
    input  logic         rd_rvalid,
    input  logic [63:0]  rd_rdata,
    output logic         cx_valid,
    output logic [63:0]  cx_addr,
    output logic [63:0]  cx_expect,
    output logic [63:0]  cx_new,
    input  logic         cx_ready,
    input  logic         cx_rvalid,
    input  logic         cx_ok,
    output logic [63:0]  new_ssp,
    output logic         done,
    output logic [1:0]   fault,
    output logic         tok_fail
);
    localparam int            DW       = SSTK_DW;
    localparam int            N_ENT    = SSTK_N_ENT;
    localparam logic [DW-1:0] FRAME_SZ = DW'(N_ENT * ENTRY_B);
    localparam logic [1:0]    USER_PL  = 2'd3;

    top_st_e                 st, st_nx;
    logic [DW-1:0]           cur_q, lip_q, restored_q, tok_q, nssp_q;
    logic [SEL_W-1:0]        sel_q;
    logic                    l_q, en_q, tokf_q;
    flt_e                    fault_q, chk_flt;
    logic [N_ENT-1:0][DW-1:0] ent;
    logic                    rdr_go, rdr_fin, wid_bad, misal, to_user;

    assign misal   = (cur_ssp[2:0] != 3'b000);
    assign to_user = (dest_pl == USER_PL);
    assign rdr_go  = (st == T_IDLE) && start && old_en && !misal && !to_user;

    sstk_frame_reader #(.DW(DW), .N_ENT(N_ENT), .ENTRY_B(ENTRY_B)) u_rdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (rdr_go),
        .base      (cur_ssp),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_ready  (rd_ready),
        .rd_rvalid (rd_rvalid),
        .rd_rdata  (rd_rdata),
        .ent_q     (ent),
        .fin       (rdr_fin)
    );

    sstk_frame_chk #(.DW(DW), .SEL_W(SEL_W), .N_ENT(N_ENT)) u_fchk (
        .sel (sel_q),
        .lip (lip_q),
        .ent (ent),
        .flt (chk_flt)
    );

    sstk_width_chk #(.DW(DW), .VA_W(VA_W)) u_wchk (
        .ssp    (restored_q),
        .long_l (l_q),
        .bad    (wid_bad)
    );

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            T_IDLE: begin
                if (start) begin
                    if (!old_en || misal) st_nx = T_FIN;
                    else if (to_user)     st_nx = T_WIDTH;
                    else                  st_nx = T_FETCH;
                end
            end
            T_FETCH:    if (rdr_fin)   st_nx = T_CHECK;
            T_CHECK:    st_nx = (chk_flt != FLT_NONE) ? T_FIN : T_WIDTH;
            T_WIDTH:    st_nx = wid_bad ? T_FIN : T_TOK_REQ;
            T_TOK_REQ:  if (cx_ready)  st_nx = T_TOK_WAIT;
            T_TOK_WAIT: if (cx_rvalid) st_nx = T_FIN;
            T_FIN:      st_nx = T_IDLE;
            default:    st_nx = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_IDLE;
        else        st <= st_nx;
    end

    // datapath registers updated along the walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            lip_q      <= '0;
            sel_q      <= '0;
            l_q        <= 1'b0;
            en_q       <= 1'b0;
            restored_q <= '0;
            tok_q      <= '0;
            nssp_q     <= '0;
            fault_q    <= FLT_NONE;
            tokf_q     <= 1'b0;
        end else begin
            unique case (st)
                T_IDLE: begin
                    if (start) begin
                        cur_q      <= cur_ssp;
                        lip_q      <= ret_lip;
                        sel_q      <= new_sel;
                        l_q        <= long_l;
                        en_q       <= old_en;
                        restored_q <= user_ssp;
                        tok_q      <= to_user ? cur_ssp : cur_ssp + FRAME_SZ;
                        nssp_q     <= cur_ssp;
                        tokf_q     <= 1'b0;
                        fault_q    <= (old_en && misal) ? FLT_CP : FLT_NONE;
                    end
                end
                T_CHECK: begin
                    if (chk_flt != FLT_NONE) fault_q    <= chk_flt;
                    else                     restored_q <= ent[IDX_PREV];
                end
                T_WIDTH: begin
                    if (wid_bad) fault_q <= FLT_GP;
                end
                T_TOK_WAIT: begin
                    if (cx_rvalid) begin
                        tokf_q <= !cx_ok;
                        nssp_q <= restored_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done      = (st == T_FIN);
        cx_valid  = (st == T_TOK_REQ);
        cx_addr   = tok_q;
        cx_expect = tok_q | 64'd1;
        cx_new    = tok_q & ~64'd1;
        new_ssp   = nssp_q;
        fault     = fault_q;
        tok_fail  = tokf_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R14
    AST_TOKEN_AFTER_CHECKS: assert property (@(posedge clk) disable iff (!rst_n)
        cx_valid |-> fault == 2'd0); // R12
    AST_FAULT_KEEPS_SSP: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault != 2'd0 |-> new_ssp == cur_q); // R14
    AST_NARROW_SSP: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault == 2'd0 && en_q && !l_q |-> new_ssp[63:32] == 32'd0); // R9
    AST_NO_READ_IN_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        cx_valid |-> !rd_valid); // R4
endmodule

// File: tb/sim_sstk_farret_verifier.sv
module sim_sstk_farret_verifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] cur_ssp = '0, ret_lip = '0, user_ssp = '0;
    logic [15:0] new_sel = '0;
    logic [1:0]  dest_pl = '0;
    logic        long_l = 1'b0, old_en = 1'b0;
    logic        rd_valid, rd_ready = 1'b0, rd_rvalid = 1'b0;
    logic [63:0] rd_addr, rd_rdata = '0;
    logic        cx_valid, cx_ready = 1'b1, cx_rvalid = 1'b0, cx_ok = 1'b0;
    logic [63:0] cx_addr, cx_expect, cx_new, new_ssp;
    logic        done, tok_fail;
    logic [1:0]  fault;

    int nchk = 0, nerr = 0;
    logic [63:0] w_sel, w_lip, w_prev;
    logic        tok_ok = 1'b1;
    int          rd_cnt = 0, cx_cnt = 0;
    logic [63:0] rd_log [0:7];
    logic [63:0] cx_a, cx_e, cx_n;

    always #5 clk = ~clk;

    sstk_farret_verifier u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_ssp(cur_ssp),
        .new_sel(new_sel), .ret_lip(ret_lip), .dest_pl(dest_pl),
        .user_ssp(user_ssp), .long_l(long_l), .old_en(old_en),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .cx_valid(cx_valid), .cx_addr(cx_addr), .cx_expect(cx_expect),
        .cx_new(cx_new), .cx_ready(cx_ready), .cx_rvalid(cx_rvalid),
        .cx_ok(cx_ok), .new_ssp(new_ssp), .done(done), .fault(fault),
        .tok_fail(tok_fail)
    );

    function automatic logic [63:0] lookup(input logic [63:0] a);
        if (a == cur_ssp + 64'd16)     return w_sel;
        else if (a == cur_ssp + 64'd8) return w_lip;
        else if (a == cur_ssp)         return w_prev;
        else                           return 64'hBAD0_BAD0_BAD0_BAD0;
    endfunction

    task automatic rd_server();
        logic        pend = 1'b0;
        logic [63:0] pa = '0;
        forever begin
            @(posedge clk);
            rd_rvalid <= 1'b0;
            if (pend) begin
                rd_rvalid <= 1'b1;
                rd_rdata  <= lookup(pa);
                pend = 1'b0;
            end else if (rd_valid && rd_ready) begin
                if (rd_cnt < 8) rd_log[rd_cnt] = rd_addr;
                rd_cnt++;
                pa   = rd_addr;
                pend = 1'b1;
            end
            rd_ready <= ~rd_ready;
        end
    endtask

    task automatic cx_server();
        logic pend = 1'b0;
        forever begin
            @(posedge clk);
            cx_rvalid <= 1'b0;
            if (pend) begin
                cx_rvalid <= 1'b1;
                cx_ok     <= tok_ok;
                pend = 1'b0;
            end else if (cx_valid && cx_ready) begin
                cx_cnt++;
                cx_a = cx_addr; cx_e = cx_expect; cx_n = cx_new;
                pend = 1'b1;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // default good frame, overridden per scenario
    task automatic setup(input logic [63:0] cur, input logic [1:0] pl, input logic l, input logic en);
        cur_ssp = cur; dest_pl = pl; long_l = l; old_en = en;
        new_sel = 16'h0033; ret_lip = 64'h0000_7FFF_1234_5678;
        user_ssp = 64'h0000_0000_3000_0000;
        w_sel = 64'h33; w_lip = 64'h0000_7FFF_1234_5678; w_prev = 64'h0000_0000_2000_0008;
        tok_ok = 1'b1; rd_cnt = 0; cx_cnt = 0;
    endtask

    task automatic run();
        int cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL R14 watchdog act=no_done exp=done");
            finish_run();
        end
    endtask

    task automatic t_reset();
        chk("R1 done", 64'(done), 0);
        chk("R1 rd_valid", 64'(rd_valid), 0);
        chk("R1 cx_valid", 64'(cx_valid), 0);
        chk("R1 fault", 64'(fault), 0);
    endtask

    task automatic t_good();
        setup(64'h1000, 2'd0, 1'b1, 1'b1);
        run();
        chk("R14 ssp", new_ssp, 64'h2000_0008);
        chk("R12 fault none", 64'(fault), 0);
        chk("R4 reads", 64'(rd_cnt), 3);
        chk("R4 addr0", rd_log[0], 64'h1010);
        chk("R4 addr1", rd_log[1], 64'h1008);
        chk("R4 addr2", rd_log[2], 64'h1000);
        chk("R12 cx count", 64'(cx_cnt), 1);
        chk("R12 cx addr", cx_a, 64'h1018);
        chk("R12 cx expect", cx_e, 64'h1019);
        chk("R12 cx new", cx_n, 64'h1018);
        chk("R13 tok ok", 64'(tok_fail), 0);
        @(negedge clk);
        chk("R14 pulse", 64'(done), 0);
    endtask

    task automatic t_disabled();
        setup(64'h1040, 2'd0, 1'b1, 1'b0);
        run();
        chk("R2 ssp", new_ssp, 64'h1040);
        chk("R2 fault", 64'(fault), 0);
        chk("R2 reads", 64'(rd_cnt), 0);
        chk("R2 cx", 64'(cx_cnt), 0);
    endtask

    task automatic t_misaligned();
        setup(64'h1004, 2'd0, 1'b1, 1'b1);
        run();
        chk("R3 fault", 64'(fault), 1);
        chk("R3 reads", 64'(rd_cnt), 0);
        chk("R3 ssp", new_ssp, 64'h1004);
    endtask

    task automatic t_sel_stray();
        setup(64'h1000, 2'd0, 1'b1, 1'b1);
        w_sel = 64'h1_0033;
        run();
        chk("R5 fault", 64'(fault), 1);
        chk("R5 no cx", 64'(cx_cnt), 0);
        chk("R14 ssp kept", new_ssp, 64'h1000);
    endtask

    task automatic t_lip_bad();
        setup(64'h1000, 2'd0, 1'b1, 1'b1);
        w_lip = 64'h0000_7FFF_1234_5679;
        run();
        chk("R6 fault", 64'(fault), 1);
        chk("R6 no cx", 64'(cx_cnt), 0);
    endtask

    task automatic t_prev_align();
        setup(64'h1000, 2'd0, 1'b1, 1'b1);
        w_prev = 64'h2000_0002;
        run();
        chk("R7 fault", 64'(fault), 1);
    endtask

    task automatic t_priority();
        setup(64'h1000, 2'd0, 1'b0, 1'b1);
        w_prev = 64'h1_0000_0002;
        run();
        chk("R8 cp over gp", 64'(fault), 1);
        chk("R8 no cx", 64'(cx_cnt), 0);
    endtask

    task automatic t_wide_l0();
        setup(64'h1000, 2'd0, 1'b0, 1'b1);
        w_prev = 64'h1_0000_0000;
        run();
        chk("R9 fault", 64'(fault), 2);
        chk("R9 ssp kept", new_ssp, 64'h1000);
        chk("R9 no cx", 64'(cx_cnt), 0);
    endtask

    task automatic t_canon();
        setup(64'h1000, 2'd0, 1'b1, 1'b1);
        w_prev = 64'h0000_8000_0000_0000;
        run();
        chk("R10 noncanon", 64'(fault), 2);
        setup(64'h1000, 2'd0, 1'b1, 1'b1);
        w_prev = 64'hFFFF_8000_0000_0000;
        run();
        chk("R10 canon ok", 64'(fault), 0);
        chk("R10 ssp", new_ssp, 64'hFFFF_8000_0000_0000);
    endtask

    task automatic t_user();
        setup(64'h1000, 2'd3, 1'b0, 1'b1);
        run();
        chk("R11 reads", 64'(rd_cnt), 0);
        chk("R11 ssp", new_ssp, 64'h3000_0000);
        chk("R11 cx addr", cx_a, 64'h1000);
        chk("R11 fault", 64'(fault), 0);
    endtask

    task automatic t_tok_fail();
        setup(64'h1000, 2'd0, 1'b1, 1'b1);
        tok_ok = 1'b0;
        run();
        chk("R13 tok_fail", 64'(tok_fail), 1);
        chk("R13 fault", 64'(fault), 0);
        chk("R13 ssp", new_ssp, 64'h2000_0008);
    endtask

    initial begin
        fork
            rd_server();
            cx_server();
        join_none
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_good();
        t_disabled();
        t_misaligned();
        t_sel_stray();
        t_lip_bad();
        t_prev_align();
        t_priority();
        t_wide_l0();
        t_canon();
        t_user();
        t_tok_fail();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL R14 global watchdog act=running exp=finished");
        finish_run();
    end
endmodule